// File: doc/BRIEF.md
# Prefixed Bit and Shift Unit

This block executes the second byte of a prefixed opcode page. A single 8-bit opcode names one of eight shift or rotate operations, a test of one bit, a clear of one bit or a set of one bit, and one of eight operand slots. The caller supplies the operand byte and the current flags. The block returns the result byte, the new flags and whether the result must be written back. For the memory slot it also reports that the operand lives in memory, so the surrounding sequencer can perform the read and, when a write-back is requested, the read-modify-write.

The block also has a second mode for the short accumulator rotates of the main opcode page. In that mode the same rotate logic runs on the accumulator, but the zero flag is always cleared. Results are registered. One request is accepted per clock, and each result appears one cycle after its request.

Top module: `bit_shift_unit`

## Requirements
- R1: After reset `outValid`, `result`, `flagsOut`, `writeBack`, `memOperand` and `slotOut` are all zero. `outValid` is high exactly in the cycle after a cycle with `inValid` high. The outputs for a request are visible in that cycle.
- R2: In prefixed mode the opcode fields decode as follows:
  - `opByte[7:6]` is the class: 00 shift group, 01 bit test, 10 bit clear, 11 bit set.
  - `opByte[5:3]` is the bit index or the shift sub-operation.
  - `opByte[2:0]` is the operand slot and is echoed on `slotOut`.
  - `memOperand` is 1 exactly when the slot is 6.
- R3: Flags are packed as {Z,N,H,C} in bits [3:0] of `flagsIn` and `flagsOut`. In the shift group, sub-operation 0 rotates left with bit 7 going to both bit 0 and C. Sub-operation 1 rotates right with bit 0 going to both bit 7 and C.
- R4: Sub-operation 2 shifts left with the old C entering bit 0 and old bit 7 becoming C. Sub-operation 3 shifts right with the old C entering bit 7 and old bit 0 becoming C.
- R5: Sub-operation 4 shifts left with a zero entering and bit 7 going to C. Sub-operation 5 shifts right keeping bit 7, with bit 0 going to C. Sub-operation 7 shifts right with a zero entering, with bit 0 going to C.
- R6: Sub-operation 6 exchanges the two nibbles and clears C whatever the incoming C.
- R7: Every shift-group operation clears N and H, sets Z exactly when the result is zero, and asserts `writeBack`.
- R8: A bit test sets H, clears N, sets Z exactly when the selected bit is 0, and passes C through. It returns the operand unchanged with `writeBack` low, including for slot 6.
- R9: A bit clear or bit set changes only the selected bit of the operand, returns `flagsIn` unchanged, and asserts `writeBack`.
- R10: With `accMode` high:
  - `opByte[4:3]` selects rotate-left-circular, rotate-right-circular, rotate-left-through-carry or rotate-right-through-carry (00, 01, 10, 11), with the same bit and carry rules as R3 and R4.
  - Z, N and H are forced to 0.
  - `slotOut` is 7, `memOperand` is 0 and `writeBack` is 1.
  - `opByte[7:5]` and `opByte[2:0]` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe |
| accMode | input | 1 | 1 selects the accumulator short-rotate mode |
| opByte | input | 8 | Prefixed opcode byte |
| operand | input | DATA_W | Operand value |
| flagsIn | input | 4 | Current flags {Z,N,H,C} |
| outValid | output | 1 | Result valid, one cycle after request |
| result | output | DATA_W | Result byte |
| flagsOut | output | 4 | New flags {Z,N,H,C} |
| writeBack | output | 1 | Result must be written to the slot |
| memOperand | output | 1 | Operand slot is memory |
| slotOut | output | 3 | Operand slot of the request |

## Verification
The bench checks that each shift variant has its own carry source. A design that shares one rule, for example feeding the old carry into a circular rotate, shows a wrong bit 0 or bit 7, or a wrong C. A result that becomes zero must raise Z in the prefixed mode and must not raise it in the accumulator mode. The bench also checks that a bit test on the memory slot still keeps `writeBack` low, and that a swap with C already set returns C cleared. Bit clear and bit set with unusual incoming flags must hand the flags back untouched, so a design that recomputes them is caught.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  localparam int OP_W   = 8;
  localparam int SLOT_W = 3;
  localparam int FLAG_W = 4;

  // flag positions inside the packed {Z,N,H,C} vector
  localparam int FZ = 3;
  localparam int FN = 2;
  localparam int FH = 1;
  localparam int FC = 0;

  localparam logic [SLOT_W-1:0] MEM_SLOT = 3'd6;
  localparam logic [SLOT_W-1:0] ACC_SLOT = 3'd7;

  typedef enum logic [1:0] {
    CLS_SHIFT = 2'b00,
    CLS_TEST  = 2'b01,
    CLS_CLEAR = 2'b10,
    CLS_SET   = 2'b11
  } opClass_e;

  typedef enum logic [2:0] {
    SH_ROTL_CIRC = 3'd0,
    SH_ROTR_CIRC = 3'd1,
    SH_ROTL_CARRY = 3'd2,
    SH_ROTR_CARRY = 3'd3,
    SH_SHL_ARITH = 3'd4,
    SH_SHR_ARITH = 3'd5,
    SH_NIBBLE    = 3'd6,
    SH_SHR_LOGIC = 3'd7
  } shiftOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic        selShift;
    logic        selTest;
    logic        selClear;
    logic        selSet;
    logic        forceZeroLow;
    logic        doWrite;
    logic        memOp;
    shiftOp_e    subOp;
    logic [2:0]  bitIdx;
    logic [SLOT_W-1:0] slot;
  } bsuCtrl_t;

endpackage

// File: rtl/bsu_ctrl.sv
module bsu_ctrl
  import bsu_pkg::*;
(
  input  logic            accMode,
  input  logic [OP_W-1:0] opByte,
  output bsuCtrl_t        ctl
);

  opClass_e cls;

  always_comb begin
    cls = opClass_e'(opByte[7:6]);
    ctl = '0;
    if (accMode) begin
      ctl.selShift     = 1'b1;
      ctl.forceZeroLow = 1'b1;
      ctl.doWrite      = 1'b1;
      ctl.memOp        = 1'b0;
      ctl.subOp        = shiftOp_e'({1'b0, opByte[4:3]});
      ctl.bitIdx       = 3'd0;
      ctl.slot         = ACC_SLOT;
    end else begin
      ctl.selShift = (cls == CLS_SHIFT);
      ctl.selTest  = (cls == CLS_TEST);
      ctl.selClear = (cls == CLS_CLEAR);
      ctl.selSet   = (cls == CLS_SET);
      ctl.doWrite  = (cls != CLS_TEST);
      ctl.subOp    = shiftOp_e'(opByte[5:3]);
      ctl.bitIdx   = opByte[5:3];
      ctl.slot     = opByte[2:0];
      ctl.memOp    = (opByte[2:0] == MEM_SLOT);
    end
  end

endmodule

// File: rtl/bsu_datapath.sv
module bsu_datapath
  import bsu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  bsuCtrl_t          ctl,
  input  logic [DATA_W-1:0] operand,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [DATA_W-1:0] resNext,
  output logic [FLAG_W-1:0] flagsNext
);

  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] selMask;
  logic [DATA_W-1:0] shRes;
  logic              shCarry;
  logic              cIn;
  logic              bitHit;

  assign cIn = flagsIn[FC];

  // one-hot mask for the addressed bit
  genvar g;
  generate
    for (g = 0; g < DATA_W; g++) begin : g_mask
      assign selMask[g] = (32'(ctl.bitIdx) == g);
    end
  endgenerate

  assign bitHit = |(operand & selMask);

  always_comb begin
    shRes   = '0;
    shCarry = 1'b0;
    unique case (ctl.subOp)
      SH_ROTL_CIRC: begin
        shRes   = {operand[DATA_W-2:0], operand[DATA_W-1]};
        shCarry = operand[DATA_W-1];
      end
      SH_ROTR_CIRC: begin
        shRes   = {operand[0], operand[DATA_W-1:1]};
        shCarry = operand[0];
      end
      SH_ROTL_CARRY: begin
        shRes   = {operand[DATA_W-2:0], cIn};
        shCarry = operand[DATA_W-1];
      end
      SH_ROTR_CARRY: begin
        shRes   = {cIn, operand[DATA_W-1:1]};
        shCarry = operand[0];
      end
      SH_SHL_ARITH: begin
        shRes   = {operand[DATA_W-2:0], 1'b0};
        shCarry = operand[DATA_W-1];
      end
      SH_SHR_ARITH: begin
        shRes   = {operand[DATA_W-1], operand[DATA_W-1:1]};
        shCarry = operand[0];
      end
      SH_NIBBLE: begin
        shRes   = {operand[HALF-1:0], operand[DATA_W-1:HALF]};
        shCarry = 1'b0;
      end
      SH_SHR_LOGIC: begin
        shRes   = {1'b0, operand[DATA_W-1:1]};
        shCarry = operand[0];
      end
      default: begin
        shRes   = operand;
        shCarry = cIn;
      end
    endcase
  end

  always_comb begin
    resNext   = operand;
    flagsNext = flagsIn;
    if (ctl.selShift) begin
      resNext       = shRes;
      flagsNext[FZ] = ctl.forceZeroLow ? 1'b0 : (shRes == '0);
      flagsNext[FN] = 1'b0;
      flagsNext[FH] = 1'b0;
      flagsNext[FC] = shCarry;
    end else if (ctl.selTest) begin
      resNext       = operand;
      flagsNext[FZ] = ~bitHit;
      flagsNext[FN] = 1'b0;
      flagsNext[FH] = 1'b1;
      flagsNext[FC] = cIn;
    end else if (ctl.selClear) begin
      resNext = operand & ~selMask;
    end else if (ctl.selSet) begin
      resNext = operand | selMask;
    end
  end

endmodule

// File: rtl/bit_shift_unit.sv
module bit_shift_unit
  import bsu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              accMode,
  input  logic [7:0]        opByte,
  input  logic [DATA_W-1:0] operand,
  input  logic [3:0]        flagsIn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flagsOut,
  output logic              writeBack,
  output logic              memOperand,
  output logic [2:0]        slotOut
);

  bsuCtrl_t          ctl;
  logic [DATA_W-1:0] resNext;
  logic [FLAG_W-1:0] flagsNext;

  bsu_ctrl u_ctrl (
    .accMode (accMode),
    .opByte  (opByte),
    .ctl     (ctl)
  );

  bsu_datapath #(.DATA_W(DATA_W)) u_dp (
    .ctl       (ctl),
    .operand   (operand),
    .flagsIn   (flagsIn),
    .resNext   (resNext),
    .flagsNext (flagsNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      result     <= '0;
      flagsOut   <= '0;
      writeBack  <= 1'b0;
      memOperand <= 1'b0;
      slotOut    <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result     <= resNext;
        flagsOut   <= flagsNext;
        writeBack  <= ctl.doWrite;
        memOperand <= ctl.memOp;
        slotOut    <= ctl.slot;
      end
    end
  end

endmodule

// File: rtl/bsu_checks.sv
module bsu_checks #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              accMode,
  input logic [7:0]        opByte,
  input logic [DATA_W-1:0] operand,
  input logic [3:0]        flagsIn,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic [3:0]        flagsOut,
  input logic              writeBack,
  input logic              memOperand,
  input logic [2:0]        slotOut
);

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (outValid == $past(inValid)));

  p_mem_slot_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && !$past(accMode))
      |-> (memOperand == ($past(opByte[2:0]) == 3'd6)));

  p_shift_nh_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && !$past(accMode) && $past(opByte[7:6]) == 2'b00)
      |-> (flagsOut[2:1] == 2'b00 && writeBack));

  p_test_no_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && !$past(accMode) && $past(opByte[7:6]) == 2'b01)
      |-> (!writeBack && flagsOut[1] && flagsOut[0] == $past(flagsIn[0])
           && result == $past(operand)));

  p_single_bit_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && !$past(accMode) && $past(opByte[7])) 
      |-> ($countones(result ^ $past(operand)) <= 1 && flagsOut == $past(flagsIn)));

  p_acc_zero_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && $past(accMode))
      |-> (flagsOut[3:1] == 3'b000 && slotOut == 3'd7 && !memOperand));

endmodule

bind bit_shift_unit bsu_checks #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_bit_shift_unit.sv
module sim_bit_shift_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       accMode = 1'b0;
  logic [7:0] opByte = '0;
  logic [7:0] operand = '0;
  logic [3:0] flagsIn = '0;
  logic       outValid;
  logic [7:0] result;
  logic [3:0] flagsOut;
  logic       writeBack;
  logic       memOperand;
  logic [2:0] slotOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bit_shift_unit #(.DATA_W(8)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .accMode(accMode),
    .opByte(opByte), .operand(operand), .flagsIn(flagsIn),
    .outValid(outValid), .result(result), .flagsOut(flagsOut),
    .writeBack(writeBack), .memOperand(memOperand), .slotOut(slotOut)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // issue one request; outputs sampled 1 ns after the capturing edge
  task automatic issue(input logic [7:0] op, input logic acc,
                       input logic [7:0] opnd, input logic [3:0] fl);
    @(negedge clk);
    opByte = op; accMode = acc; operand = opnd; flagsIn = fl; inValid = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic release_req;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic expect_out(input string tag, input logic [7:0] res,
                            input logic [3:0] fl, input logic wb);
    chk({tag, " valid"}, outValid, 1'b1);
    chk({tag, " result"}, result, res);
    chk({tag, " flags"}, flagsOut, fl);
    chk({tag, " writeBack"}, writeBack, wb);
    release_req();
  endtask

  task automatic t_reset;
    chk("R1 reset valid", outValid, 1'b0);
    chk("R1 reset result", result, 8'h00);
    chk("R1 reset flags", flagsOut, 4'h0);
    chk("R1 reset wb", {writeBack, memOperand, slotOut}, 5'd0);
  endtask

  task automatic t_circular;
    issue(8'h00, 1'b0, 8'h85, 4'b0000);
    expect_out("R3 rotl circ", 8'h0B, 4'b0001, 1'b1);
    issue(8'h09, 1'b0, 8'h01, 4'b0000);
    expect_out("R3 rotr circ", 8'h80, 4'b0001, 1'b1);
  endtask

  task automatic t_through_carry;
    issue(8'h10, 1'b0, 8'h80, 4'b0000);
    expect_out("R4 R7 rotl carry zero", 8'h00, 4'b1001, 1'b1);
    issue(8'h18, 1'b0, 8'h01, 4'b0001);
    expect_out("R4 rotr carry", 8'h80, 4'b0001, 1'b1);
    issue(8'h12, 1'b0, 8'h40, 4'b0111);
    expect_out("R4 R7 rotl carry in", 8'h81, 4'b0000, 1'b1);
  endtask

  task automatic t_shifts;
    issue(8'h20, 1'b0, 8'hFF, 4'b0000);
    expect_out("R5 shl arith", 8'hFE, 4'b0001, 1'b1);
    issue(8'h28, 1'b0, 8'h81, 4'b0000);
    expect_out("R5 shr arith", 8'hC0, 4'b0001, 1'b1);
    issue(8'h38, 1'b0, 8'h81, 4'b0000);
    expect_out("R5 shr logic", 8'h40, 4'b0001, 1'b1);
    issue(8'h38, 1'b0, 8'h01, 4'b0000);
    expect_out("R5 R7 shr logic zero", 8'h00, 4'b1001, 1'b1);
  endtask

  task automatic t_swap;
    issue(8'h30, 1'b0, 8'hF0, 4'b0001);
    expect_out("R6 swap clears carry", 8'h0F, 4'b0000, 1'b1);
    issue(8'h30, 1'b0, 8'h00, 4'b0111);
    expect_out("R6 R7 swap zero", 8'h00, 4'b1000, 1'b1);
  endtask

  task automatic t_bit_test;
    issue(8'h79, 1'b0, 8'h7F, 4'b0101);
    chk("R2 slot echo", slotOut, 3'd1);
    chk("R2 not mem", memOperand, 1'b0);
    expect_out("R8 test clear bit", 8'h7F, 4'b1011, 1'b0);
    issue(8'h46, 1'b0, 8'h01, 4'b0000);
    chk("R2 R8 mem slot", memOperand, 1'b1);
    expect_out("R8 test mem no wb", 8'h01, 4'b0010, 1'b0);
  endtask

  task automatic t_clear_set;
    issue(8'h9E, 1'b0, 8'hFF, 4'b1010);
    chk("R2 R9 mem rmw", memOperand, 1'b1);
    expect_out("R9 clear bit3", 8'hF7, 4'b1010, 1'b1);
    issue(8'hC7, 1'b0, 8'h00, 4'b0101);
    chk("R2 slot7", slotOut, 3'd7);
    expect_out("R9 set bit0", 8'h01, 4'b0101, 1'b1);
    issue(8'hF8, 1'b0, 8'h00, 4'b1111);
    expect_out("R9 set bit7", 8'h80, 4'b1111, 1'b1);
  endtask

  task automatic t_acc_mode;
    issue(8'h06, 1'b1, 8'h00, 4'b1110);
    chk("R10 acc slot", slotOut, 3'd7);
    chk("R10 acc not mem", memOperand, 1'b0);
    expect_out("R10 acc rotl circ zero", 8'h00, 4'b0000, 1'b1);
    issue(8'hD0, 1'b1, 8'h80, 4'b0000);
    expect_out("R10 acc rotl carry", 8'h00, 4'b0001, 1'b1);
    issue(8'h5F, 1'b1, 8'h01, 4'b0001);
    expect_out("R10 acc rotr carry", 8'h80, 4'b0001, 1'b1);
    issue(8'h08, 1'b1, 8'h02, 4'b0001);
    expect_out("R10 acc rotr circ", 8'h01, 4'b0000, 1'b1);
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk("R1 idle no valid", outValid, 1'b0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_circular();
    t_through_carry();
    t_shifts();
    t_swap();
    t_bit_test();
    t_clear_set();
    t_acc_mode();
    t_idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule